// File: doc/BRIEF.md
# Multi-channel display interrupt controller

This block collects error and progress events from a compositor that feeds three display output channels and turns them into status bits, one summary bit per channel and a single interrupt line. Each channel delivers one-cycle pulses for six conditions:
- end of frame: the channel leaves its running state for its end-of-frame state;
- underflow: the downstream consumer reads an empty display FIFO;
- short line: a horizontal start arrives while pixels of the current output line are still pending;
- short frame: a vertical start arrives in that same situation;
- end of line N: the programmed line has finished compositing;
- output buffer low.

Every pulse sets a sticky bit in that channel's byte lane of the status word.

Software programs a control word with these fields:
- a global enable;
- per-channel enables for end-of-frame, end-of-line-N and underflow/short-line reporting;
- a per-channel interrupt enable;
- enables for the DMA, slave-access and profiler sources;
- a two-bit select field that the block only stores.

Software reads the status word to find the cause of an interrupt. It clears sticky bits one at a time by writing 1 to them, or clears everything at once by writing 1 to bit 0. The register port is a plain single-cycle write strobe with a combinational read. Events are pulses with no handshake, because they cannot be held back: a pulse is never lost.

Top module: `disp_irq_ctrl`

## Requirements
- R1: The control word is at byte offset 0x0 and resets to 0. The writable bits are 31 (global enable), 19:18 (select field), 15:13, 12:7, 6:4, 3:1 and 0. Every other bit reads 0, so writing all ones reads back 0x800CFFFF.
- R2: For channel x, a pulse sets status bit (x+1)*8+k one clock later. k is 0 for end of frame, 1 for underflow, 2 for short line, 3 for short frame, 4 for end of line N and 5 for output buffer low. The bit then stays set until it is cleared.
- R3: Writing status (offset 0x4) with a 1 in an event bit clears only that bit. A pulse for the same bit in the same cycle wins, so the bit stays set.
- R4: Status bit 1+x (the channel summary) is 1 only when control bit 1+x is set and at least one of these holds: end of frame is set with control bit 7+2x, end of line N is set with control bit 8+2x, or underflow or short line is set with control bit 13+x.
- R5: A short-frame bit feeds the channel summary whenever control bit 1+x is set, whatever the per-event enables. The output-buffer-low bit never feeds the summary.
- R6: Status bit 7 latches an invalid-DMA-ID pulse, bit 6 a slave-read error and bit 5 a slave-write error. Bits 15:14 hold the latest non-zero bus response code (2 slave error, 3 decode error); a response of 0 (okay) is ignored. Writing 1 to bit 14 or 15 clears the code. Bit 4 is set when bit 7 or a non-zero code is present with control bit 4, bit 6 with control bit 6, or bit 5 with control bit 5.
- R7: Writing status with bit 0 set clears every sticky bit, the response code and the profiler event. Pulses arriving in that same cycle still set their bits.
- R8: Status bit 0 reads as the latched profiler event ANDed with control bit 0.
- R9: The irq output is the OR of status bits 3:1, bit 4 and bit 0, ANDed with control bit 31. It is low whenever control bit 31 is clear.
- R10: Writes to any offset other than 0x0 and 0x4 change nothing, and reads there return 0.
- R11: After reset, both words read 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| eof_p | input | NUM_CH | End-of-frame pulse per channel |
| uflow_p | input | NUM_CH | Underflow pulse per channel |
| sline_p | input | NUM_CH | Short-line pulse per channel |
| sframe_p | input | NUM_CH | Short-frame pulse per channel |
| eoln_p | input | NUM_CH | End-of-line-N pulse per channel |
| buflow_p | input | NUM_CH | Output-buffer-low pulse per channel |
| dma_id_err_p | input | 1 | Invalid DMA ID pulse |
| slv_rd_err_p | input | 1 | Slave read error pulse |
| slv_wr_err_p | input | 1 | Slave write error pulse |
| resp_valid | input | 1 | Qualifies resp_code |
| resp_code | input | 2 | Bus response code |
| prof_p | input | 1 | Profiler event pulse |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with NUM_CH=3 and ADDR_W=8. Three channels fill every lane of the status word, so neighbouring lanes, the response field between lanes 0 and 1 and the top lane at bits 29:24 are all exercised together. An 8-bit offset brings an unmapped offset (0x8) within reach, so ignored writes and zero reads can be checked. A vector table sweeps enable and event combinations per channel. Directed tests then cover same-cycle set/clear races, the clear-all write, the error and response sources, and the profiler gating.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int REG_W  = 32;
  localparam int EV_N   = 6;
  // event slot inside a channel lane
  localparam int EV_EOF    = 0;
  localparam int EV_UFLOW  = 1;
  localparam int EV_SLINE  = 2;
  localparam int EV_SFRAME = 3;
  localparam int EV_EOLN   = 4;
  localparam int EV_BUFLOW = 5;
  // control word bits
  localparam int C_GLOBAL = 31;
  localparam int C_PROF   = 0;
  localparam int C_DMA    = 4;
  localparam int C_SWR    = 5;
  localparam int C_SRD    = 6;
  localparam int C_MUX_LO = 18;
  localparam int C_MUX_HI = 19;
  // status word bits
  localparam int S_PROF    = 0;
  localparam int S_DMA     = 4;
  localparam int S_SWR     = 5;
  localparam int S_SRD     = 6;
  localparam int S_DMAID   = 7;
  localparam int S_RESP_LO = 14;
  localparam int S_RESP_HI = 15;

  function automatic int c_chirq(int x); return 1 + x; endfunction
  function automatic int c_eof(int x);   return 7 + 2 * x; endfunction
  function automatic int c_eoln(int x);  return 8 + 2 * x; endfunction
  function automatic int c_urun(int x);  return 13 + x; endfunction
  function automatic int s_chsum(int x); return 1 + x; endfunction
  function automatic int lane_base(int x); return (x + 1) * 8; endfunction

  function automatic logic [REG_W-1:0] ctrl_mask(int n);
    logic [REG_W-1:0] m;
    m = '0;
    m[C_GLOBAL] = 1'b1;
    m[C_MUX_HI] = 1'b1;
    m[C_MUX_LO] = 1'b1;
    m[C_PROF]   = 1'b1;
    m[C_DMA]    = 1'b1;
    m[C_SWR]    = 1'b1;
    m[C_SRD]    = 1'b1;
    for (int x = 0; x < n; x++) begin
      m[c_chirq(x)] = 1'b1;
      m[c_eof(x)]   = 1'b1;
      m[c_eoln(x)]  = 1'b1;
      m[c_urun(x)]  = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/dirq_ctrl.sv
module dirq_ctrl
  import dirq_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_q
);
  localparam logic [REG_W-1:0] WMASK = ctrl_mask(NUM_CH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata & WMASK;
  end

  // R1: unimplemented bits never hold a 1
  assert_ctrl_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~WMASK) == '0);
  // R1/R10: the word only moves on a decoded write
  assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/dirq_lane.sv
module dirq_lane
  import dirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_N-1:0] evt,
  input  logic [EV_N-1:0] clr,
  input  logic            en_eof,
  input  logic            en_eoln,
  input  logic            en_urun,
  input  logic            en_ch,
  output logic [EV_N-1:0] flags,
  output logic            summary
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | evt;
  end

  always_comb begin
    summary = en_ch & ((flags[EV_EOF] & en_eof)
                     | (flags[EV_EOLN] & en_eoln)
                     | ((flags[EV_UFLOW] | flags[EV_SLINE]) & en_urun)
                     | flags[EV_SFRAME]);
  end

  // R3: a pulse sets its bit even when a clear hits in the same cycle
  assert_event_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));
  // R2: uncleared bits stay set
  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));
  // R2: no bit rises without its pulse
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(evt)) == '0));
  // R5: a latched short frame drives the summary when the channel is enabled
  assert_sframe_counts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[EV_SFRAME] && en_ch) |-> summary);
endmodule

// File: rtl/dirq_misc.sv
module dirq_misc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dma_id_err_p,
  input  logic       slv_rd_err_p,
  input  logic       slv_wr_err_p,
  input  logic       resp_valid,
  input  logic [1:0] resp_code,
  input  logic       prof_p,
  input  logic       clr_all,
  input  logic       clr_dmaid,
  input  logic       clr_srd,
  input  logic       clr_swr,
  input  logic       clr_resp,
  input  logic       en_dma,
  input  logic       en_srd,
  input  logic       en_swr,
  input  logic       en_prof,
  output logic       dmaid_q,
  output logic       srd_q,
  output logic       swr_q,
  output logic [1:0] resp_q,
  output logic       dma_sum,
  output logic       prof_int
);
  logic prof_q;
  logic resp_err;

  assign resp_err = resp_valid && (resp_code != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmaid_q <= 1'b0;
      srd_q   <= 1'b0;
      swr_q   <= 1'b0;
      resp_q  <= 2'd0;
      prof_q  <= 1'b0;
    end else begin
      dmaid_q <= (dmaid_q & ~(clr_all | clr_dmaid)) | dma_id_err_p;
      srd_q   <= (srd_q & ~(clr_all | clr_srd)) | slv_rd_err_p;
      swr_q   <= (swr_q & ~(clr_all | clr_swr)) | slv_wr_err_p;
      prof_q  <= (prof_q & ~clr_all) | prof_p;
      if (resp_err)                 resp_q <= resp_code;
      else if (clr_all || clr_resp) resp_q <= 2'd0;
    end
  end

  always_comb begin
    dma_sum  = (en_dma & (dmaid_q | (resp_q != 2'd0)))
             | (en_srd & srd_q) | (en_swr & swr_q);
    prof_int = prof_q & en_prof;
  end

  // R6: an okay response leaves the stored code untouched
  assert_okay_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!resp_err && !clr_all && !clr_resp) |=> $stable(resp_q));
  // R7: clear-all empties the error bits when nothing new arrives
  assert_clear_errors_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !dma_id_err_p && !slv_rd_err_p && !slv_wr_err_p && !resp_err)
      |=> (!dmaid_q && !srd_q && !swr_q && resp_q == 2'd0));
endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
  import dirq_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_CH-1:0] eof_p,
  input  logic [NUM_CH-1:0] uflow_p,
  input  logic [NUM_CH-1:0] sline_p,
  input  logic [NUM_CH-1:0] sframe_p,
  input  logic [NUM_CH-1:0] eoln_p,
  input  logic [NUM_CH-1:0] buflow_p,
  input  logic              dma_id_err_p,
  input  logic              slv_rd_err_p,
  input  logic              slv_wr_err_p,
  input  logic              resp_valid,
  input  logic [1:0]        resp_code,
  input  logic              prof_p,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(4);

  logic              wr_ctrl, wr_stat, clr_all;
  logic [31:0]       w1c;
  logic [31:0]       ctrl_q;
  logic [31:0]       stat_w;
  logic [EV_N-1:0]   lane_flags [NUM_CH];
  logic [NUM_CH-1:0] ch_sum;
  logic              dmaid_q, srd_q, swr_q, dma_sum, prof_int;
  logic [1:0]        resp_q;
  logic              any_evt;

  assign wr_ctrl = reg_wr && (reg_addr == OFF_CTRL);
  assign wr_stat = reg_wr && (reg_addr == OFF_STAT);
  assign w1c     = wr_stat ? reg_wdata : 32'd0;
  assign clr_all = w1c[S_PROF];

  dirq_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(reg_wdata), .ctrl_q(ctrl_q)
  );

  for (genvar x = 0; x < NUM_CH; x++) begin : g_lane
    logic [EV_N-1:0] evt;
    assign evt = {buflow_p[x], eoln_p[x], sframe_p[x], sline_p[x], uflow_p[x], eof_p[x]};
    dirq_lane u_lane (
      .clk(clk), .rst_n(rst_n), .evt(evt),
      .clr(w1c[lane_base(x) +: EV_N] | {EV_N{clr_all}}),
      .en_eof(ctrl_q[c_eof(x)]), .en_eoln(ctrl_q[c_eoln(x)]),
      .en_urun(ctrl_q[c_urun(x)]), .en_ch(ctrl_q[c_chirq(x)]),
      .flags(lane_flags[x]), .summary(ch_sum[x])
    );
  end

  dirq_misc u_misc (
    .clk(clk), .rst_n(rst_n),
    .dma_id_err_p(dma_id_err_p), .slv_rd_err_p(slv_rd_err_p), .slv_wr_err_p(slv_wr_err_p),
    .resp_valid(resp_valid), .resp_code(resp_code), .prof_p(prof_p),
    .clr_all(clr_all), .clr_dmaid(w1c[S_DMAID]), .clr_srd(w1c[S_SRD]), .clr_swr(w1c[S_SWR]),
    .clr_resp(w1c[S_RESP_LO] | w1c[S_RESP_HI]),
    .en_dma(ctrl_q[C_DMA]), .en_srd(ctrl_q[C_SRD]), .en_swr(ctrl_q[C_SWR]),
    .en_prof(ctrl_q[C_PROF]),
    .dmaid_q(dmaid_q), .srd_q(srd_q), .swr_q(swr_q), .resp_q(resp_q),
    .dma_sum(dma_sum), .prof_int(prof_int)
  );

  always_comb begin
    stat_w = '0;
    for (int x = 0; x < NUM_CH; x++) begin
      stat_w[lane_base(x) +: EV_N] = lane_flags[x];
      stat_w[s_chsum(x)]           = ch_sum[x];
    end
    stat_w[S_RESP_HI:S_RESP_LO] = resp_q;
    stat_w[S_DMAID] = dmaid_q;
    stat_w[S_SRD]   = srd_q;
    stat_w[S_SWR]   = swr_q;
    stat_w[S_DMA]   = dma_sum;
    stat_w[S_PROF]  = prof_int;
  end

  always_comb begin
    if (reg_addr == OFF_CTRL)      reg_rdata = ctrl_q;
    else if (reg_addr == OFF_STAT) reg_rdata = stat_w;
    else                           reg_rdata = 32'd0;
  end

  assign irq = ctrl_q[C_GLOBAL] & ((|ch_sum) | dma_sum | prof_int);

  assign any_evt = (|eof_p) | (|uflow_p) | (|sline_p) | (|sframe_p) | (|eoln_p)
                 | (|buflow_p) | dma_id_err_p | slv_rd_err_p | slv_wr_err_p
                 | (resp_valid && resp_code != 2'd0) | prof_p;

  // R9: no interrupt without the global enable
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[C_GLOBAL] |-> !irq);
  // R7: clear-all with no new pulse leaves an empty status word
  assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !any_evt) |=> (stat_w == 32'd0));
  // R10: stray offsets leave the control word alone
  assert_bad_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != OFF_CTRL) |=> $stable(ctrl_q));
endmodule

// File: tb/sim_disp_irq_ctrl.sv
module sim_disp_irq_ctrl;
  localparam int NCH = 3;
  localparam int NV  = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NCH-1:0] eof_p = '0, uflow_p = '0, sline_p = '0, sframe_p = '0, eoln_p = '0, buflow_p = '0;
  logic dma_id_err_p = 1'b0, slv_rd_err_p = 1'b0, slv_wr_err_p = 1'b0, resp_valid = 1'b0, prof_p = 1'b0;
  logic [1:0] resp_code = '0;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  disp_irq_ctrl #(.NUM_CH(NCH), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .eof_p(eof_p), .uflow_p(uflow_p), .sline_p(sline_p),
    .sframe_p(sframe_p), .eoln_p(eoln_p), .buflow_p(buflow_p), .dma_id_err_p(dma_id_err_p),
    .slv_rd_err_p(slv_rd_err_p), .slv_wr_err_p(slv_wr_err_p), .resp_valid(resp_valid),
    .resp_code(resp_code), .prof_p(prof_p), .irq(irq)
  );

  // per channel x: bits 6x+k of an event pattern, k = eof,uflow,sline,sframe,eoln,buflow
  localparam logic [31:0] T_CTRL [NV] = '{32'h80000082, 32'h80000004, 32'h80000004,
    32'h80008008, 32'h00008008, 32'h80002182, 32'h80002180, 32'h8000FFFE, 32'h8000040E};
  localparam logic [17:0] T_EV [NV] = '{18'h00001, 18'h00040, 18'h00200,
    18'h04000, 18'h02000, 18'h00020, 18'h00011, 18'h3FFFF, 18'h00410};
  localparam logic [2:0] T_SUM [NV] = '{3'b001, 3'b000, 3'b010,
    3'b100, 3'b100, 3'b000, 3'b000, 3'b111, 3'b010};
  localparam logic T_IRQ [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  function automatic logic [31:0] lane_exp(logic [17:0] ev);
    logic [31:0] s = '0;
    for (int x = 0; x < NCH; x++)
      for (int k = 0; k < 6; k++) s[(x + 1) * 8 + k] = ev[6 * x + k];
    return s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic drive_ev(logic [17:0] ev);
    for (int x = 0; x < NCH; x++) begin
      eof_p[x] = ev[6*x]; uflow_p[x] = ev[6*x+1]; sline_p[x] = ev[6*x+2];
      sframe_p[x] = ev[6*x+3]; eoln_p[x] = ev[6*x+4]; buflow_p[x] = ev[6*x+5];
    end
  endtask

  task automatic pulse_ev(logic [17:0] ev);
    @(negedge clk); drive_ev(ev);
    @(negedge clk); drive_ev('0);
  endtask

  task automatic chk_stat(string req, logic [31:0] exp_s, logic exp_i);
    logic [31:0] d;
    rd(8'h4, d);
    check(req, d, exp_s);
    check({req, " irq"}, {31'd0, irq}, {31'd0, exp_i});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    rd(8'h0, d); check("R11 ctrl after reset", d, 32'h0);
    chk_stat("R11 status after reset", 32'h0, 1'b0);

    // R1: writable mask
    wr(8'h0, 32'hFFFFFFFF); rd(8'h0, d); check("R1 ctrl mask", d, 32'h800CFFFF);
    wr(8'h0, 32'h0);        rd(8'h0, d); check("R1 ctrl zero", d, 32'h0);

    // vector table: R2 lanes, R4 summary, R5 sframe/buflow, R9 gating
    for (int i = 0; i < NV; i++) begin
      wr(8'h4, 32'h1);
      wr(8'h0, T_CTRL[i]);
      pulse_ev(T_EV[i]);
      chk_stat($sformatf("R2/R4/R5/R9 vector %0d", i),
               lane_exp(T_EV[i]) | {28'd0, T_SUM[i], 1'b0}, T_IRQ[i]);
    end

    // R3: individual clear and event-wins race
    wr(8'h4, 32'h1); wr(8'h0, 32'h0);
    pulse_ev(18'h01041);
    chk_stat("R2 eof all channels", 32'h01010100, 1'b0);
    wr(8'h4, 32'h00010000);
    chk_stat("R3 single bit clear", 32'h01000100, 1'b0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h4; reg_wdata = 32'h100; eof_p[0] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; eof_p[0] = 1'b0;
    chk_stat("R3 event wins over clear", 32'h01000100, 1'b0);

    // R7: clear-all with simultaneous event
    @(negedge clk); resp_valid = 1'b1; resp_code = 2'd3;
    @(negedge clk); resp_valid = 1'b0; resp_code = 2'd0;
    chk_stat("R6 resp latched", 32'h0100C100, 1'b0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h4; reg_wdata = 32'h1; buflow_p[2] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; buflow_p[2] = 1'b0;
    chk_stat("R7 clear all keeps new event", 32'h20000000, 1'b0);

    // R10: unmapped offset
    wr(8'h8, 32'hFFFFFFFF);
    rd(8'h8, d); check("R10 unmapped read", d, 32'h0);
    rd(8'h0, d); check("R10 ctrl untouched", d, 32'h0);
    chk_stat("R10 status untouched", 32'h20000000, 1'b0);

    // R6: error sources
    wr(8'h4, 32'h1); wr(8'h0, 32'h80000010);
    @(negedge clk); dma_id_err_p = 1'b1;
    @(negedge clk); dma_id_err_p = 1'b0;
    chk_stat("R6 dma id", 32'h00000090, 1'b1);
    @(negedge clk); resp_valid = 1'b1; resp_code = 2'd2;
    @(negedge clk); resp_valid = 1'b0; resp_code = 2'd0;
    chk_stat("R6 resp slave error", 32'h00008090, 1'b1);
    wr(8'h4, 32'h80);
    chk_stat("R6 clear dma id keeps resp", 32'h00008010, 1'b1);
    wr(8'h4, 32'h8000);
    chk_stat("R6 clear resp", 32'h0, 1'b0);
    @(negedge clk); resp_valid = 1'b1; resp_code = 2'd0;
    @(negedge clk); resp_valid = 1'b0;
    chk_stat("R6 okay ignored", 32'h0, 1'b0);
    wr(8'h0, 32'h80000000);
    @(negedge clk); slv_rd_err_p = 1'b1;
    @(negedge clk); slv_rd_err_p = 1'b0;
    chk_stat("R6 slave read unenabled", 32'h00000040, 1'b0);
    wr(8'h0, 32'h80000040);
    chk_stat("R6 slave read enabled", 32'h00000050, 1'b1);
    wr(8'h4, 32'h1); wr(8'h0, 32'h80000020);
    @(negedge clk); slv_wr_err_p = 1'b1;
    @(negedge clk); slv_wr_err_p = 1'b0;
    chk_stat("R6 slave write enabled", 32'h00000030, 1'b1);

    // R8: profiler
    wr(8'h4, 32'h1); wr(8'h0, 32'h80000000);
    @(negedge clk); prof_p = 1'b1;
    @(negedge clk); prof_p = 1'b0;
    chk_stat("R8 profiler masked", 32'h0, 1'b0);
    wr(8'h0, 32'h80000001);
    chk_stat("R8 profiler enabled", 32'h1, 1'b1);
    wr(8'h4, 32'h1);
    chk_stat("R8 profiler cleared", 32'h0, 1'b0);

    finish_run();
  end
endmodule